// File: doc/BRIEF.md
# Protection Level Lifecycle Controller

This block holds the device's current protection level. Level 0 is open, level 1 protects the memories and level 2 closes the device. At start-up it reads a stored level code and decodes it. Any code it does not recognise is taken as the closed level. From the current level it drives three outputs: the debug permission, the set of allowed boot sources, and whether the stored options may still be written.

Firmware or a programming agent may ask for a new level at any time.

- A request to raise the level, or to keep it, is always accepted.
- A request to lower the level is judged by two lock bits and two key-check results supplied from outside.
- Lowering from 1 to 0 first asks the erase engine to wipe user flash. The level commits only when that engine reports completion.
- Lowering from 2 to 1 needs no erase.
- Every accepted or refused request produces a one-cycle response. A refusal also sets a sticky flag.

Top module: `prot_level_ctrl`

## Requirements
- R1: While reset is held the level reads 2. One clock edge after reset release the level reflects the stored code: CODE_OPEN gives 0, CODE_PROT gives 1, and every other code gives 2.
- R2: debugMode is 2'd0 (full access) at level 0, 2'd1 (limited, no memory access) at level 1, and 2'd2 (disabled) at level 2.
- R3: In bootMask, bit0 is user flash, bit1 is system memory and bit2 is SRAM. The mask is 3'b111 at levels 0 and 1 and 3'b001 at level 2.
- R4: optWritable is 1 at levels 0 and 1. At level 2 it equals closeLock.
- R5: A request whose target is at or above the current level is granted, with reqLevel 3 treated as 2. The level changes at the sampling edge, and after that same edge respValid=1 and respGrant=1 for one cycle.
- R6: A request from 1 to 0 with openLock=0, or with openKeyOk=1, enters the erase phase. eraseReq rises after the sampling edge and no response is given yet.
- R7: During the erase phase, eraseReq stays 1, the level stays 1 and new requests are ignored. At the edge that samples eraseDone=1 the level becomes 0 and eraseReq drops, and a granted response follows.
- R8: A request from 1 to 0 with openLock=1 and openKeyOk=0 is denied.
- R9: A request from 2 to 1 is granted, with no erase, only when closeLock=1 and closeKeyOk=1. Otherwise it is denied.
- R10: A request from 2 to 0 is always denied.
- R11: A denied request leaves the level unchanged, gives respValid=1 with respGrant=0, and sets denied. The next granted request clears denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| storedCode | input | CODE_W | Stored level code, read once after reset |
| openLock | input | 1 | 1: lowering 1 to 0 needs the open key |
| closeLock | input | 1 | 1: lowering 2 to 1 is possible with the close key |
| openKeyOk | input | 1 | Open-key unlock sequence succeeded |
| closeKeyOk | input | 1 | Close-key unlock sequence succeeded |
| reqValid | input | 1 | Level change request strobe |
| reqLevel | input | 2 | Requested level (3 means 2) |
| eraseDone | input | 1 | Mass erase finished |
| curLevel | output | 2 | Current protection level |
| debugMode | output | 2 | Debug permission code |
| bootMask | output | BOOT_N | Allowed boot sources |
| optWritable | output | 1 | Stored options may be written |
| eraseReq | output | 1 | Mass erase request |
| respValid | output | 1 | Response strobe |
| respGrant | output | 1 | Response is a grant |
| denied | output | 1 | Sticky refusal flag |

## Verification
On every cycle the assertions check the following:
- The level never drops from 1 to 0 unless an erase phase has ended with eraseDone.
- The level stays at 1 while the erase request is raised.
- The level never falls straight from 2 to 0.
- A 2-to-1 step only happens with both close-lock and close-key true.
- A refusal leaves the level untouched.

Only the bench's sweeps can show the rest:
- Full decoding of every stored code.
- The grant/deny matrix across all lock and key combinations for each start level and target.
- That requests arriving mid-erase are dropped.
- That the sticky flag clears on the next grant.

// File: rtl/prot_pkg.sv
package prot_pkg;

  typedef enum logic [1:0] {
    LVL_OPEN   = 2'd0,
    LVL_PROT   = 2'd1,
    LVL_CLOSED = 2'd2
  } lvl_e;

  typedef enum logic [1:0] {
    DBG_FULL    = 2'd0,
    DBG_LIMITED = 2'd1,
    DBG_NONE    = 2'd2
  } dbg_e;

  typedef enum logic [1:0] {
    ST_LOAD  = 2'd0,
    ST_IDLE  = 2'd1,
    ST_ERASE = 2'd2
  } ctl_state_e;

  typedef struct packed {
    logic load;
    logic setLvl;
    lvl_e newLvl;
    logic grant;
    logic deny;
  } ctl_strobe_t;

  function automatic lvl_e clampLevel(input logic [1:0] raw);
    if (raw == 2'd0) return LVL_OPEN;
    if (raw == 2'd1) return LVL_PROT;
    return LVL_CLOSED;
  endfunction

endpackage

// File: rtl/prot_ctrl_fsm.sv
module prot_ctrl_fsm
  import prot_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  lvl_e        curLevel,
  input  logic        openLock,
  input  logic        closeLock,
  input  logic        openKeyOk,
  input  logic        closeKeyOk,
  input  logic        reqValid,
  input  logic [1:0]  reqLevel,
  input  logic        eraseDone,
  output ctl_strobe_t strobe,
  output logic        eraseReq
);

  ctl_state_e state, stateNext;
  lvl_e       target;
  logic       isRaise;
  logic       openAllowed;
  logic       closeAllowed;

  assign target       = clampLevel(reqLevel);
  assign isRaise      = (2'(target) >= 2'(curLevel));
  assign openAllowed  = !openLock || openKeyOk;
  assign closeAllowed = closeLock && closeKeyOk;

  always_comb begin
    stateNext     = state;
    strobe.load   = 1'b0;
    strobe.setLvl = 1'b0;
    strobe.newLvl = curLevel;
    strobe.grant  = 1'b0;
    strobe.deny   = 1'b0;
    unique case (state)
      ST_LOAD: begin
        strobe.load = 1'b1;
        stateNext   = ST_IDLE;
      end
      ST_IDLE: begin
        if (reqValid) begin
          if (isRaise) begin
            strobe.setLvl = 1'b1;
            strobe.newLvl = target;
            strobe.grant  = 1'b1;
          end else if (curLevel == LVL_PROT) begin
            if (openAllowed) stateNext = ST_ERASE;
            else             strobe.deny = 1'b1;
          end else if (curLevel == LVL_CLOSED && target == LVL_PROT) begin
            if (closeAllowed) begin
              strobe.setLvl = 1'b1;
              strobe.newLvl = LVL_PROT;
              strobe.grant  = 1'b1;
            end else begin
              strobe.deny = 1'b1;
            end
          end else begin
            strobe.deny = 1'b1;
          end
        end
      end
      ST_ERASE: begin
        if (eraseDone) begin
          strobe.setLvl = 1'b1;
          strobe.newLvl = LVL_OPEN;
          strobe.grant  = 1'b1;
          stateNext     = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_LOAD;
    else       state <= stateNext;
  end

  assign eraseReq = (state == ST_ERASE);

  AST_OPEN_AFTER_ERASE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(curLevel) == LVL_PROT && curLevel == LVL_OPEN) |-> ($past(state) == ST_ERASE && $past(eraseDone))); // R7
  AST_ERASE_HOLDS_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    eraseReq |-> curLevel == LVL_PROT); // R7
  AST_CLOSE_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) != ST_LOAD && $past(curLevel) == LVL_CLOSED && curLevel == LVL_PROT) |-> $past(closeLock && closeKeyOk)); // R9
  AST_NO_SKIP_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) != ST_LOAD && $past(curLevel) == LVL_CLOSED) |-> curLevel != LVL_OPEN); // R10

endmodule

// File: rtl/prot_level_dp.sv
module prot_level_dp
  import prot_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter logic [CODE_W-1:0] CODE_OPEN = 8'h5A,
  parameter logic [CODE_W-1:0] CODE_PROT = 8'hC3,
  parameter int BOOT_N = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] storedCode,
  input  logic              closeLock,
  input  ctl_strobe_t       strobe,
  output lvl_e              level,
  output logic [1:0]        debugMode,
  output logic [BOOT_N-1:0] bootMask,
  output logic              optWritable,
  output logic              respValid,
  output logic              respGrant,
  output logic              denied
);

  localparam int FLASH_BIT = 0;

  lvl_e decoded;
  dbg_e dbgSel;

  always_comb begin
    if (storedCode == CODE_OPEN)      decoded = LVL_OPEN;
    else if (storedCode == CODE_PROT) decoded = LVL_PROT;
    else                              decoded = LVL_CLOSED;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              level <= LVL_CLOSED;
    else if (strobe.load)   level <= decoded;
    else if (strobe.setLvl) level <= strobe.newLvl;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respGrant <= 1'b0;
      denied    <= 1'b0;
    end else begin
      respValid <= strobe.grant | strobe.deny;
      respGrant <= strobe.grant;
      if (strobe.deny)       denied <= 1'b1;
      else if (strobe.grant) denied <= 1'b0;
    end
  end

  always_comb begin
    unique case (level)
      LVL_OPEN: dbgSel = DBG_FULL;
      LVL_PROT: dbgSel = DBG_LIMITED;
      default:  dbgSel = DBG_NONE;
    endcase
  end
  assign debugMode = 2'(dbgSel);

  for (genvar b = 0; b < BOOT_N; b++) begin : g_boot
    if (b == FLASH_BIT) begin : g_flash
      assign bootMask[b] = 1'b1;
    end else begin : g_other
      assign bootMask[b] = (level != LVL_CLOSED);
    end
  end

  assign optWritable = (level != LVL_CLOSED) || closeLock;

  AST_DENY_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respGrant) |-> $stable(level)); // R11
  AST_DENIED_ON_REFUSAL: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respGrant) |-> denied); // R11

endmodule

// File: rtl/prot_level_ctrl.sv
module prot_level_ctrl
  import prot_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter logic [CODE_W-1:0] CODE_OPEN = 8'h5A,
  parameter logic [CODE_W-1:0] CODE_PROT = 8'hC3,
  parameter int BOOT_N = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] storedCode,
  input  logic              openLock,
  input  logic              closeLock,
  input  logic              openKeyOk,
  input  logic              closeKeyOk,
  input  logic              reqValid,
  input  logic [1:0]        reqLevel,
  input  logic              eraseDone,
  output logic [1:0]        curLevel,
  output logic [1:0]        debugMode,
  output logic [BOOT_N-1:0] bootMask,
  output logic              optWritable,
  output logic              eraseReq,
  output logic              respValid,
  output logic              respGrant,
  output logic              denied
);

  ctl_strobe_t strobe;
  lvl_e        level;

  prot_ctrl_fsm u_ctrl (
    .clk(clk), .rstN(rstN), .curLevel(level),
    .openLock(openLock), .closeLock(closeLock),
    .openKeyOk(openKeyOk), .closeKeyOk(closeKeyOk),
    .reqValid(reqValid), .reqLevel(reqLevel), .eraseDone(eraseDone),
    .strobe(strobe), .eraseReq(eraseReq)
  );

  prot_level_dp #(
    .CODE_W(CODE_W), .CODE_OPEN(CODE_OPEN), .CODE_PROT(CODE_PROT), .BOOT_N(BOOT_N)
  ) u_dp (
    .clk(clk), .rstN(rstN), .storedCode(storedCode), .closeLock(closeLock),
    .strobe(strobe), .level(level), .debugMode(debugMode), .bootMask(bootMask),
    .optWritable(optWritable), .respValid(respValid), .respGrant(respGrant),
    .denied(denied)
  );

  assign curLevel = 2'(level);

  AST_ERASE_NO_RESP: assert property (@(posedge clk) disable iff (!rstN)
    (eraseReq && $past(eraseReq)) |-> !respValid); // R7

endmodule

// File: tb/prot_level_ctrl_bench.sv
module prot_level_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] C_OPEN = 8'h5A;
  localparam logic [7:0] C_PROT = 8'hC3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] storedCode = 8'h00;
  logic openLock = 0, closeLock = 0, openKeyOk = 0, closeKeyOk = 0;
  logic reqValid = 0;
  logic [1:0] reqLevel = 0;
  logic eraseDone = 0;
  logic [1:0] curLevel, debugMode;
  logic [2:0] bootMask;
  logic optWritable, eraseReq, respValid, respGrant, denied;

  int total = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prot_level_ctrl u_prot_level_ctrl (
    .clk(clk), .rstN(rstN), .storedCode(storedCode),
    .openLock(openLock), .closeLock(closeLock),
    .openKeyOk(openKeyOk), .closeKeyOk(closeKeyOk),
    .reqValid(reqValid), .reqLevel(reqLevel), .eraseDone(eraseDone),
    .curLevel(curLevel), .debugMode(debugMode), .bootMask(bootMask),
    .optWritable(optWritable), .eraseReq(eraseReq),
    .respValid(respValid), .respGrant(respGrant), .denied(denied)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chkEq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic startUp(input logic [7:0] code, input bit checkReset);
    @(negedge clk);
    rstN = 1'b0;
    reqValid = 0;
    eraseDone = 0;
    storedCode = code;
    @(posedge clk);
    @(negedge clk);
    if (checkReset) begin
      chkEq("R1 reset level", curLevel, 2);
      chkEq("R7 reset eraseReq", eraseReq, 0);
      chkEq("R11 reset resp/denied", {respValid, denied}, 0);
    end
    rstN = 1'b1;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic request(input logic [1:0] lvl);
    reqLevel = lvl;
    reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    bit first = 1;
    // R1..R4: decode every stored code
    for (int c = 0; c < 256; c++) begin
      int expLvl;
      closeLock = c[0];
      startUp(8'(c), first);
      first = 0;
      expLvl = (8'(c) == C_OPEN) ? 0 : (8'(c) == C_PROT) ? 1 : 2;
      chkEq("R1 decoded level", curLevel, expLvl);
      chkEq("R2 debug mode", debugMode, expLvl);
      chkEq("R3 boot mask", bootMask, (expLvl == 2) ? 1 : 7);
      chkEq("R4 options writable", optWritable, (expLvl < 2) ? 1 : int'(c[0]));
    end

    // R5..R11: request matrix
    for (int s = 0; s < 3; s++) begin
      for (int t = 0; t < 4; t++) begin
        for (int m = 0; m < 16; m++) begin
          int tc;
          bit goErase, grant;
          logic [7:0] code;
          code = (s == 0) ? C_OPEN : (s == 1) ? C_PROT : 8'hFF;
          openLock = m[0]; closeLock = m[1]; openKeyOk = m[2]; closeKeyOk = m[3];
          startUp(code, 0);
          tc = (t > 2) ? 2 : t;
          goErase = 0;
          grant = 0;
          if (tc >= s) grant = 1;
          else if (s == 1) goErase = !m[0] || m[2];
          else if (s == 2 && tc == 1) grant = m[1] && m[3];
          request(2'(t));
          if (goErase) begin
            chkEq("R6 erase request raised", eraseReq, 1);
            chkEq("R6 no response yet", respValid, 0);
            chkEq("R6 level held", curLevel, 1);
            for (int k = 0; k < 3; k++) begin
              request(2'd2);
              chkEq("R7 erase holds", {eraseReq, curLevel}, 3'b101);
              chkEq("R7 request ignored", respValid, 0);
            end
            eraseDone = 1'b1;
            @(posedge clk);
            @(negedge clk);
            eraseDone = 1'b0;
            chkEq("R7 level open after erase", curLevel, 0);
            chkEq("R7 erase dropped", eraseReq, 0);
            chkEq("R7 grant response", {respValid, respGrant}, 3);
          end else if (grant) begin
            chkEq("R5 R9 granted level", curLevel, tc);
            chkEq("R5 R9 grant response", {respValid, respGrant}, 3);
            chkEq("R9 no erase", eraseReq, 0);
            chkEq("R11 denied clear", denied, 0);
          end else begin
            chkEq("R8 R9 R10 R11 level unchanged", curLevel, s);
            chkEq("R11 deny response", {respValid, respGrant}, 2);
            chkEq("R11 denied set", denied, 1);
            chkEq("R6 no erase on deny", eraseReq, 0);
            request(2'd2);
            chkEq("R11 denied cleared by grant", denied, 0);
            chkEq("R5 raise to closed", curLevel, 2);
          end
        end
      end
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule